// File: doc/BRIEF.md
# Timing Marker Relay

This block carries an optional 8 kHz synchronisation marker across a multi-port cell link. On the transmit side each port raises a marker request towards its cell encoder. The request comes from one of two sources, chosen per port. The first is a local reference clock of any duty cycle, resynchronised into the core clock domain, where each falling edge counts as one marker. The second is loopback, where every marker command decoded on that port's receive side is sent straight back out. A request stays pending until the encoder acknowledges it. Further markers that arrive while a request is pending merge into it.

On the receive side, the decoders deliver one-cycle strobes, one per port, each marking a decoded marker command. A selector picks which port drives the single receive reference output. Each strobe on that port drives the output low for a programmable number of clock cycles. The longer widths are meant for systems where the core clock runs at a multiple of the line symbol rate.

Top module: `timing_marker_relay`

## Requirements
- R1: After reset, `tx_mark_req` is all zeros and `rx_ref_n` is high.
- R2: In local mode (`tx_src_sel[i]`=0), a falling edge on `tx_ref_in[i]` sets `tx_mark_req[i]` at the third rising clock edge after the input changes, which allows two synchroniser flops plus the request flop. A rising edge produces no request.
- R3: A local reference held high produces no request.
- R4: In loop mode (`tx_src_sel[i]`=1), an `rx_mark_stb[i]` pulse sets `tx_mark_req[i]` at the next clock edge. `tx_ref_in[i]` has no effect in this mode.
- R5: In local mode, `rx_mark_stb[i]` does not set `tx_mark_req[i]`.
- R6: A set `tx_mark_req[i]` stays set until a clock edge at which `tx_mark_ack[i]` is high. At that edge it clears, unless a new trigger arrives in the same cycle.
- R7: Several triggers that arrive while a request is pending merge into one request, which a single acknowledge clears.
- R8: A trigger in the same cycle as an acknowledge leaves the request set.
- R9: A strobe on the port selected by `rx_src_sel` drives `rx_ref_n` low from the next clock edge. The low time is 1, 2, 4 or 8 cycles for `rx_width_sel` codes 0, 1, 2 and 3.
- R10: Strobes on ports other than the selected one leave `rx_ref_n` high.
- R11: A selected strobe that arrives while the output is low restarts the full low time.
- R12: Each port's transmit request path works independently of the other ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_src_sel | input | NUM_PORTS | Per-port transmit source: 0 local reference, 1 loopback |
| tx_ref_in | input | NUM_PORTS | Per-port asynchronous local reference clocks |
| rx_mark_stb | input | NUM_PORTS | One-cycle strobes from the decoders, one per port |
| tx_mark_ack | input | NUM_PORTS | Encoder acknowledge of a marker request |
| rx_src_sel | input | PORT_W | Port whose received markers drive `rx_ref_n` |
| rx_width_sel | input | WSEL_W | Low-time code for `rx_ref_n` |
| tx_mark_req | output | NUM_PORTS | Pending marker request to each encoder |
| rx_ref_n | output | 1 | Active-low receive reference pulse |

## Verification
The transmit path is driven with falling edges, rising edges and a held-high reference. This separates edge detection from level sensing and pins down the synchroniser latency. Loopback strobes are tried singly, in bursts while a request is pending, and coincident with an acknowledge, which shows whether requests are held, merged or lost. On the receive side, each width code is measured, strobes are sent on unselected ports, and a second strobe arrives mid-pulse. These show whether the source mux and the width counter restart correctly.

// File: rtl/tm_pkg.sv
package tm_pkg;
  typedef enum logic {
    TX_SRC_LOCAL = 1'b0,
    TX_SRC_LOOP  = 1'b1
  } tx_src_e;
endpackage

// File: rtl/tm_ref_sync.sv
module tm_ref_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic fall
);
  localparam int DEPTH = SYNC_STAGES + 1;

  logic [DEPTH-1:0] shift_q;
  logic [DEPTH-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[DEPTH-2:0], ref_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '1;
    else        shift_q <= shift_d;
  end

  assign fall = shift_q[DEPTH-1] & ~shift_q[DEPTH-2];
endmodule

// File: rtl/tm_tx_pend.sv
module tm_tx_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic ack,
  output logic req
);
  logic pend_q;
  logic pend_d;
  logic pend_en;

  always_comb begin
    pend_en = trig | ack;
    pend_d  = trig | (pend_q & ~ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign req = pend_q;
endmodule

// File: rtl/tm_rx_pulse.sv
module tm_rx_pulse #(
  parameter int NUM_PORTS = 4,
  parameter int SEL_W     = 2,
  parameter int WSEL_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] stb,
  input  logic [SEL_W-1:0]     src_sel,
  input  logic [WSEL_W-1:0]    width_sel,
  output logic                 ref_n
);
  localparam int CNT_W = (1 << WSEL_W);

  logic             hit;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    hit = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (src_sel == SEL_W'(p)) hit = stb[p];
    end
  end

  always_comb begin
    cnt_en = hit | (cnt_q != '0);
    if (hit) cnt_d = CNT_W'(1) << width_sel;
    else     cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ref_n = (cnt_q == '0);
endmodule

// File: rtl/timing_marker_relay.sv
module timing_marker_relay #(
  parameter int NUM_PORTS   = 4,
  parameter int SYNC_STAGES = 2,
  parameter int WSEL_W      = 2,
  localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] tx_src_sel,
  input  logic [NUM_PORTS-1:0] tx_ref_in,
  input  logic [NUM_PORTS-1:0] rx_mark_stb,
  input  logic [NUM_PORTS-1:0] tx_mark_ack,
  input  logic [PORT_W-1:0]    rx_src_sel,
  input  logic [WSEL_W-1:0]    rx_width_sel,
  output logic [NUM_PORTS-1:0] tx_mark_req,
  output logic                 rx_ref_n
);
  logic [NUM_PORTS-1:0] ref_fall;
  logic [NUM_PORTS-1:0] tx_trig;

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    tm_ref_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_in (tx_ref_in[i]),
      .fall   (ref_fall[i])
    );

    always_comb begin
      if (tm_pkg::tx_src_e'(tx_src_sel[i]) == tm_pkg::TX_SRC_LOOP)
        tx_trig[i] = rx_mark_stb[i];
      else
        tx_trig[i] = ref_fall[i];
    end

    tm_tx_pend u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .trig  (tx_trig[i]),
      .ack   (tx_mark_ack[i]),
      .req   (tx_mark_req[i])
    );
  end

  tm_rx_pulse #(
    .NUM_PORTS (NUM_PORTS),
    .SEL_W     (PORT_W),
    .WSEL_W    (WSEL_W)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (rx_mark_stb),
    .src_sel   (rx_src_sel),
    .width_sel (rx_width_sel),
    .ref_n     (rx_ref_n)
  );
endmodule

// File: rtl/timing_marker_relay_chk.sv
module timing_marker_relay_chk #(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2,
  parameter int WSEL_W    = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] tx_src_sel,
  input logic [NUM_PORTS-1:0] rx_mark_stb,
  input logic [NUM_PORTS-1:0] tx_mark_ack,
  input logic [PORT_W-1:0]    rx_src_sel,
  input logic [NUM_PORTS-1:0] tx_mark_req,
  input logic                 rx_ref_n
);
  localparam int MAX_LOW = 1 << ((1 << WSEL_W) - 1);

  logic [15:0] low_run;
  logic        sel_stb;

  always_comb begin
    sel_stb = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (rx_src_sel == PORT_W'(p)) sel_stb = rx_mark_stb[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         low_run <= '0;
    else if (rx_ref_n)  low_run <= '0;
    else if (sel_stb)   low_run <= 16'd1;
    else                low_run <= low_run + 16'd1;
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_chk
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mark_req[i] && !tx_mark_ack[i]) |=> tx_mark_req[i]);

    assert_loop_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_mark_stb[i] && tx_src_sel[i]) |=> tx_mark_req[i]);

    assert_collide_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_mark_stb[i] && tx_src_sel[i] && tx_mark_ack[i]) |=> tx_mark_req[i]);
  end

  assert_rx_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stb |=> !rx_ref_n);

  assert_width_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= 16'(MAX_LOW));
endmodule

bind timing_marker_relay timing_marker_relay_chk #(
  .NUM_PORTS (NUM_PORTS),
  .PORT_W    (PORT_W),
  .WSEL_W    (WSEL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_src_sel  (tx_src_sel),
  .rx_mark_stb (rx_mark_stb),
  .tx_mark_ack (tx_mark_ack),
  .rx_src_sel  (rx_src_sel),
  .tx_mark_req (tx_mark_req),
  .rx_ref_n    (rx_ref_n)
);

// File: tb/test_timing_marker_relay.sv
module test_timing_marker_relay;
  logic       clk;
  logic       rst_n;
  logic [3:0] tx_src_sel;
  logic [3:0] tx_ref_in;
  logic [3:0] rx_mark_stb;
  logic [3:0] tx_mark_ack;
  logic [1:0] rx_src_sel;
  logic [1:0] rx_width_sel;
  logic [3:0] tx_mark_req;
  logic       rx_ref_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  timing_marker_relay i_timing_marker_relay (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_src_sel   (tx_src_sel),
    .tx_ref_in    (tx_ref_in),
    .rx_mark_stb  (rx_mark_stb),
    .tx_mark_ack  (tx_mark_ack),
    .rx_src_sel   (rx_src_sel),
    .rx_width_sel (rx_width_sel),
    .tx_mark_req  (tx_mark_req),
    .rx_ref_n     (rx_ref_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic nstep(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    tx_mark_ack = 4'hF;
    nstep(1);
    tx_mark_ack = 4'h0;
    nstep(10);
  endtask

  task automatic t_reset();
    check("R1 req", 32'(tx_mark_req), 32'h0);
    check("R1 ref_n", 32'(rx_ref_n), 32'h1);
  endtask

  task automatic t_local_edge();
    tx_src_sel = 4'b0000;
    tx_ref_in[0] = 1'b0;
    nstep(2);
    check("R2 not early", 32'(tx_mark_req[0]), 32'h0);
    nstep(1);
    check("R2 fall sets", 32'(tx_mark_req[0]), 32'h1);
    clear_all();
    tx_ref_in[0] = 1'b1;
    nstep(6);
    check("R2 rise none", 32'(tx_mark_req[0]), 32'h0);
  endtask

  task automatic t_held_high();
    tx_src_sel = 4'b0000;
    tx_ref_in  = 4'hF;
    nstep(20);
    check("R3 held high", 32'(tx_mark_req), 32'h0);
  endtask

  task automatic t_loop();
    tx_src_sel = 4'b0010;
    rx_mark_stb[1] = 1'b1;
    nstep(1);
    rx_mark_stb[1] = 1'b0;
    check("R4 loop sets", 32'(tx_mark_req[1]), 32'h1);
    clear_all();
    tx_ref_in[1] = 1'b0;
    nstep(6);
    tx_ref_in[1] = 1'b1;
    nstep(6);
    check("R4 local ignored", 32'(tx_mark_req[1]), 32'h0);
  endtask

  task automatic t_local_ignores_rx();
    tx_src_sel = 4'b0000;
    rx_mark_stb[2] = 1'b1;
    nstep(1);
    rx_mark_stb[2] = 1'b0;
    nstep(3);
    check("R5 rx ignored", 32'(tx_mark_req[2]), 32'h0);
    nstep(10);
  endtask

  task automatic t_hold_ack();
    tx_src_sel = 4'b0010;
    rx_mark_stb[1] = 1'b1;
    nstep(1);
    rx_mark_stb[1] = 1'b0;
    nstep(10);
    check("R6 held", 32'(tx_mark_req[1]), 32'h1);
    tx_mark_ack[1] = 1'b1;
    nstep(1);
    tx_mark_ack[1] = 1'b0;
    check("R6 ack clears", 32'(tx_mark_req[1]), 32'h0);
    nstep(10);
  endtask

  task automatic t_merge();
    tx_src_sel = 4'b0010;
    for (int k = 0; k < 3; k++) begin
      rx_mark_stb[1] = 1'b1;
      nstep(1);
      rx_mark_stb[1] = 1'b0;
      nstep(1);
    end
    check("R7 pending", 32'(tx_mark_req[1]), 32'h1);
    tx_mark_ack[1] = 1'b1;
    nstep(1);
    tx_mark_ack[1] = 1'b0;
    nstep(2);
    check("R7 single ack", 32'(tx_mark_req[1]), 32'h0);
    nstep(10);
  endtask

  task automatic t_collide();
    tx_src_sel = 4'b0010;
    rx_mark_stb[1] = 1'b1;
    nstep(1);
    tx_mark_ack[1] = 1'b1;
    nstep(1);
    rx_mark_stb[1] = 1'b0;
    tx_mark_ack[1] = 1'b0;
    check("R8 collide keeps", 32'(tx_mark_req[1]), 32'h1);
    tx_mark_ack[1] = 1'b1;
    nstep(1);
    tx_mark_ack[1] = 1'b0;
    check("R8 then clears", 32'(tx_mark_req[1]), 32'h0);
    nstep(10);
  endtask

  task automatic measure_low(output int lows);
    lows = 0;
    for (int k = 0; k < 20; k++) begin
      if (!rx_ref_n) lows++;
      nstep(1);
    end
  endtask

  task automatic t_width();
    int lows;
    tx_src_sel = 4'b0000;
    rx_src_sel = 2'd0;
    for (int c = 0; c < 4; c++) begin
      rx_width_sel = 2'(c);
      rx_mark_stb[0] = 1'b1;
      nstep(1);
      rx_mark_stb[0] = 1'b0;
      check("R9 low at once", 32'(rx_ref_n), 32'h0);
      measure_low(lows);
      check("R9 width", 32'(lows), 32'(1 << c));
    end
  endtask

  task automatic t_other_src();
    int lows;
    rx_src_sel   = 2'd2;
    rx_width_sel = 2'd3;
    rx_mark_stb  = 4'b1011;
    nstep(1);
    rx_mark_stb  = 4'b0000;
    measure_low(lows);
    check("R10 others ignored", 32'(lows), 32'h0);
    rx_mark_stb[2] = 1'b1;
    nstep(1);
    rx_mark_stb[2] = 1'b0;
    measure_low(lows);
    check("R10 selected drives", 32'(lows), 32'h8);
  endtask

  task automatic t_retrigger();
    int lows;
    rx_src_sel   = 2'd3;
    rx_width_sel = 2'd2;
    rx_mark_stb[3] = 1'b1;
    nstep(1);
    rx_mark_stb[3] = 1'b0;
    nstep(1);
    rx_mark_stb[3] = 1'b1;
    nstep(1);
    rx_mark_stb[3] = 1'b0;
    measure_low(lows);
    check("R11 restart", 32'(lows + 2), 32'h6);
    clear_all();
  endtask

  task automatic t_independent();
    tx_src_sel = 4'b1000;
    tx_ref_in[0]   = 1'b0;
    rx_mark_stb[3] = 1'b1;
    nstep(1);
    rx_mark_stb[3] = 1'b0;
    check("R12 loop port only", 32'(tx_mark_req), 32'h8);
    nstep(2);
    check("R12 both", 32'(tx_mark_req), 32'h9);
    tx_mark_ack[3] = 1'b1;
    nstep(1);
    tx_mark_ack[3] = 1'b0;
    check("R12 ack one port", 32'(tx_mark_req), 32'h1);
    tx_ref_in[0] = 1'b1;
    clear_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n        = 1'b0;
    tx_src_sel   = 4'h0;
    tx_ref_in    = 4'hF;
    rx_mark_stb  = 4'h0;
    tx_mark_ack  = 4'h0;
    rx_src_sel   = 2'd0;
    rx_width_sel = 2'd0;
    nstep(3);
    rst_n = 1'b1;
    nstep(2);
    t_reset();
    t_local_edge();
    t_held_high();
    t_loop();
    t_local_ignores_rx();
    t_hold_ack();
    t_merge();
    t_collide();
    t_width();
    t_other_src();
    t_retrigger();
    t_independent();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule